// File: doc/BRIEF.md
# UART Baud Tick and Break Timer

This block produces the timing strobes that a UART transmitter and receiver need, derived from the system clock. The clock passes through three cascaded divide stages. The first is a programmable pre-divider. The second is a fixed stage that divides by 13 and marks each oversample point. The third is a programmable bit divisor. The output of the last stage marks the bit boundaries.

Software writes a divisor word. The new value is held as pending, and a busy flag stays high until the next bit boundary, where the new value takes over. A second function uses the same bit tick to time a line break. A programmed break length, counted in bit periods, sets how long the break-active output (transmit line forced low) stays asserted after a start strobe. A one-cycle done pulse marks the end of the break.

The block holds no serial data, so it has no valid/ready streams. Every pin is a plain control or status level, or a single-cycle strobe.

Top module: `ubt_baud_break`

## Requirements
- R1: After reset, busy, brk_active and brk_done are 0. Both dividers are 0, so os_tick and bit_tick each pulse once every 13 clock cycles.
- R2: os_tick is a one-cycle pulse with a period of (P+1)*13 clocks. P is the active pre-divider value, taken from cfg_wdata[19:16] of a divisor write.
- R3: bit_tick is a one-cycle pulse that coincides with an os_tick. Its period is (P+1)*13*(D+1) clocks, where D comes from cfg_wdata[9:0]. All other bits of the divisor word are ignored.
- R4: A write with cfg_we=1 and cfg_sel=0 sets busy from the next cycle. busy stays high until the first bit_tick after the write and reads 0 in the cycle after that bit_tick. The new P and D govern the bit period that starts at that boundary.
- R5: A second divisor write while busy is high replaces the pending value. Only the last value written takes effect.
- R6: A write with cfg_sel=1 stores the break length N from cfg_wdata[15:0]. A brk_start pulse while idle raises brk_active in the next cycle. brk_active stays high through exactly N bit_ticks and drops after the N-th. A length of 0 behaves as 1.
- R7: brk_done is high for exactly one cycle, namely the first cycle in which brk_active reads 0 after a break. It is never high while brk_active is high.
- R8: brk_start while a break is active is ignored and does not change the break length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 divisor word, 1 break length |
| cfg_wdata | input | 32 | Configuration write data |
| brk_start | input | 1 | Starts a break when none is active |
| busy | output | 1 | Divisor update pending |
| os_tick | output | 1 | Oversample strobe |
| bit_tick | output | 1 | Bit boundary strobe |
| brk_active | output | 1 | Break in progress; transmit line held low |
| brk_done | output | 1 | One-cycle pulse at break end |

## Verification
A wrong count or limit in any divide stage changes the spacing of os_tick or bit_tick. This shows up within one bit period, so the bench measures tick spacing directly against the formula for each programmed divisor. A pending value that is applied too early, too late or not at all shows up in the cycle where busy falls and in the length of the next bit period. A fault in the break counter changes the number of bit ticks seen while brk_active is high, or the timing of the done pulse. Either one becomes visible no later than one bit period after the break should have ended.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int UBT_PD_W     = 4;
  localparam int UBT_BD_W     = 10;
  localparam int UBT_OS_RATIO = 13;
  localparam int UBT_BRK_W    = 16;
  localparam int UBT_CFG_W    = 32;
  localparam int UBT_PD_LSB   = 16;

  typedef enum logic {
    CFG_DIVISOR   = 1'b0,
    CFG_BREAK_LEN = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/ubt_tick_div.sv
module ubt_tick_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = en && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tick)    cnt <= '0;
    else if (en)      cnt <= cnt + 1'b1;
  end

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> (cnt != '0));
endmodule

// File: rtl/ubt_div_ctrl.sv
module ubt_div_ctrl #(
  parameter int PD_W = 4,
  parameter int BD_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [PD_W-1:0] wr_pd,
  input  logic [BD_W-1:0] wr_bd,
  input  logic            bit_tick,
  output logic [PD_W-1:0] pd_lim,
  output logic [BD_W-1:0] bd_lim,
  output logic            busy
);
  logic [PD_W-1:0] pend_pd;
  logic [BD_W-1:0] pend_bd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_pd <= '0;
      pend_bd <= '0;
      pd_lim  <= '0;
      bd_lim  <= '0;
      busy    <= 1'b0;
    end else if (wr) begin
      pend_pd <= wr_pd;
      pend_bd <= wr_bd;
      busy    <= 1'b1;
    end else if (busy && bit_tick) begin
      pd_lim  <= pend_pd;
      bd_lim  <= pend_bd;
      busy    <= 1'b0;
    end
  end

  assert_busy_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr));
  assert_busy_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_tick && !wr) |=> !busy);
  assert_limits_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && bit_tick) |=> $stable(pd_lim) && $stable(bd_lim));
endmodule

// File: rtl/ubt_break_timer.sv
module ubt_break_timer #(
  parameter int BRK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [BRK_W-1:0] len_wdata,
  input  logic             start,
  input  logic             bit_tick,
  output logic             active,
  output logic             done
);
  logic [BRK_W-1:0] len_q;
  logic [BRK_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      remain <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (len_wr) len_q <= len_wdata;
      if (!active && start) begin
        active <= 1'b1;
        remain <= (len_q == '0) ? BRK_W'(1) : len_q;
      end else if (active && bit_tick) begin
        if (remain == BRK_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          remain <= '0;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end

  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!active && $past(active)));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_tick) |=> (active && $stable(remain)));
  assert_remain_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remain != '0));
endmodule

// File: rtl/ubt_baud_break.sv
module ubt_baud_break
  import ubt_pkg::*;
#(
  parameter int PD_W     = UBT_PD_W,
  parameter int BD_W     = UBT_BD_W,
  parameter int OS_RATIO = UBT_OS_RATIO,
  parameter int BRK_W    = UBT_BRK_W,
  parameter int CFG_W    = UBT_CFG_W,
  parameter int PD_LSB   = UBT_PD_LSB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             brk_start,
  output logic             busy,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             brk_active,
  output logic             brk_done
);
  localparam int OS_W = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;
  localparam logic [OS_W-1:0] OS_LIM = OS_W'(OS_RATIO - 1);

  logic            div_wr;
  logic            len_wr;
  logic [PD_W-1:0] pd_lim;
  logic [BD_W-1:0] bd_lim;
  logic            pre_tick;

  assign div_wr = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_DIVISOR);
  assign len_wr = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_BREAK_LEN);

  ubt_div_ctrl #(.PD_W(PD_W), .BD_W(BD_W)) u_div_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (div_wr),
    .wr_pd    (cfg_wdata[PD_LSB +: PD_W]),
    .wr_bd    (cfg_wdata[BD_W-1:0]),
    .bit_tick (bit_tick),
    .pd_lim   (pd_lim),
    .bd_lim   (bd_lim),
    .busy     (busy)
  );

  ubt_tick_div #(.W(PD_W)) u_prediv (
    .clk (clk), .rst_n (rst_n), .en (1'b1), .lim (pd_lim), .tick (pre_tick)
  );

  ubt_tick_div #(.W(OS_W)) u_oversample (
    .clk (clk), .rst_n (rst_n), .en (pre_tick), .lim (OS_LIM), .tick (os_tick)
  );

  ubt_tick_div #(.W(BD_W)) u_bitdiv (
    .clk (clk), .rst_n (rst_n), .en (os_tick), .lim (bd_lim), .tick (bit_tick)
  );

  ubt_break_timer #(.BRK_W(BRK_W)) u_break (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_wr    (len_wr),
    .len_wdata (cfg_wdata[BRK_W-1:0]),
    .start     (brk_start),
    .bit_tick  (bit_tick),
    .active    (brk_active),
    .done      (brk_done)
  );

  assert_bit_on_os_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  assert_os_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);
  assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_done && brk_active));
endmodule

// File: tb/ubt_baud_break_bench.sv
module ubt_baud_break_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        brk_start = 1'b0;
  logic        busy, os_tick, bit_tick, brk_active, brk_done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ubt_baud_break u_ubt_baud_break (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
    .cfg_wdata (cfg_wdata), .brk_start (brk_start), .busy (busy),
    .os_tick (os_tick), .bit_tick (bit_tick), .brk_active (brk_active),
    .brk_done (brk_done)
  );

  function automatic int exp_os(int pd);
    return (pd + 1) * 13;
  endfunction

  function automatic int exp_bit(int pd, int bd);
    return (pd + 1) * 13 * (bd + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic meas_bit(output int p);
    do @(negedge clk); while (!bit_tick);
    p = 0;
    do begin @(negedge clk); p++; end while (!bit_tick);
  endtask

  task automatic meas_os(output int p);
    do @(negedge clk); while (!os_tick);
    p = 0;
    do begin @(negedge clk); p++; end while (!os_tick);
  endtask

  // Apply a divisor word and follow the busy flag to the boundary (R4).
  task automatic apply_div(logic [31:0] word, int pd, int bd, bit twice, logic [31:0] first);
    int p;
    bit held;
    if (twice) wr(1'b0, first);
    wr(1'b0, word);
    chk(busy == 1'b1, "R4 busy after write", int'(busy), 1);
    held = 1'b1;
    while (!bit_tick) begin
      if (!busy) held = 1'b0;
      @(negedge clk);
    end
    chk(held && busy, "R4 busy held until boundary", int'(held), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R4 busy cleared after boundary", int'(busy), 0);
    p = 1;
    while (!bit_tick) begin @(negedge clk); p++; end
    chk(p == exp_bit(pd, bd), twice ? "R5 last write applies" : "R4 first period new divisor",
        p, exp_bit(pd, bd));
    meas_bit(p);
    chk(p == exp_bit(pd, bd), "R3 bit period", p, exp_bit(pd, bd));
    meas_os(p);
    chk(p == exp_os(pd), "R2 oversample period", p, exp_os(pd));
  endtask

  task automatic run_break(int len, bit poke);
    int ticks;
    int expn;
    bit done_clean;
    bit poked;
    expn = (len == 0) ? 1 : len;
    wr(1'b1, 32'(len) | 32'hABCD_0000);
    @(negedge clk); brk_start = 1'b1;
    @(negedge clk); brk_start = 1'b0;
    chk(brk_active == 1'b1, "R6 break starts", int'(brk_active), 1);
    ticks = 0; done_clean = 1'b1; poked = 1'b0;
    while (brk_active) begin
      if (brk_done) done_clean = 1'b0;
      if (bit_tick) ticks++;
      brk_start = 1'b0;
      if (poke && !poked && ticks == 1) begin brk_start = 1'b1; poked = 1'b1; end
      @(negedge clk);
    end
    brk_start = 1'b0;
    chk(ticks == expn, poke ? "R8 start during break ignored" : "R6 break length",
        ticks, expn);
    chk(done_clean, "R7 no done while active", int'(done_clean), 1);
    chk(brk_done == 1'b1, "R7 done at break end", int'(brk_done), 1);
    @(negedge clk);
    chk(brk_done == 1'b0, "R7 done one cycle", int'(brk_done), 0);
    chk(brk_active == 1'b0, "R8 no restart from ignored start", int'(brk_active), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    int pd;
    int bd;
    logic [31:0] junk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(brk_active == 1'b0, "R1 break reset", int'(brk_active), 0);
    chk(brk_done == 1'b0, "R1 done reset", int'(brk_done), 0);
    meas_os(p);
    chk(p == 13, "R1 oversample period", p, 13);
    meas_bit(p);
    chk(p == 13, "R1 bit period", p, 13);

    // Directed corners
    apply_div(32'h000F_0001, 15, 1, 1'b0, '0);
    apply_div(32'h0000_03FF, 0, 1023, 1'b0, '0);
    apply_div(32'h0002_0003, 2, 3, 1'b1, 32'h0009_0010);

    // Random divisors with junk in unused bits (R3)
    for (int i = 0; i < 6; i++) begin
      pd = int'($urandom_range(0, 3));
      bd = int'($urandom_range(0, 15));
      junk = $urandom() & 32'hFFF0_FC00;
      apply_div(junk | (32'(pd) << 16) | 32'(bd), pd, bd, i[0], $urandom());
    end

    apply_div(32'h0000_0002, 0, 2, 1'b0, '0);
    run_break(5, 1'b1);
    run_break(0, 1'b0);
    run_break(1, 1'b0);
    run_break(int'($urandom_range(2, 6)), 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule